// File: doc/BRIEF.md
# Two-Stage Reboot Watchdog Timer

This block is a watchdog with a small register interface. Software loads a tick count, clears a halt bit and then writes a reload register at regular intervals. A prescaler turns the core clock into coarse ticks, and a down-counter counts those ticks from the programmed period. If software fails to reload in time, the counter expires. The first expiry only raises a timeout flag. The counter then refills itself and counts once more. A second expiry with no reload in between raises a one-cycle system reset request.

A board strap input or a configuration bit can veto the reset request. When the reset is vetoed, the second expiry is still recorded in status. The three status flags are cleared by writing ones to them. In the intended flow, software halts the timer, writes a new period with a read-modify-write that keeps the upper six bits, clears halt and then reloads. Software keeps the period between roughly 2 s and 613 s worth of ticks.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the halt bit (bit 0 at address 0) is 1, the period register (address 2) reads 0x03FF, status (address 3) reads 0, the veto bit (address 4) reads 0, the count (address 5) reads 0x03FF and `sys_reset_req` is low.
- R2: While halt is 1, neither the count nor the prescaler phase changes. When halt is cleared, counting resumes from the frozen count and prescaler phase.
- R3: A write of any value to address 1 loads the count from the period field, restarts the prescaler phase and re-arms the first stage. This applies whether the timer is halted or running, so a reload between the two expiries prevents the second one.
- R4: Bits 9:0 of address 2 hold the period in ticks. Bits 15:10 are stored and read back, and they have no effect on counting.
- R5: While running, the count drops by one every PRESCALE clocks. The first expiry comes exactly period×PRESCALE clocks after a reload and sets the timeout flag (status bit 0).
- R6: On every expiry the count refills from the period. An expiry while the second stage is armed sets status bit 1. If no veto is active, it also sets the boot flag (status bit 2) and raises `sys_reset_req` for exactly one cycle, in the cycle after that clock edge. The stage then returns to first, so repeated neglect gives a pulse every two periods.
- R7: When either `no_reboot_strap` or the veto bit (bit 0 at address 4) is 1, a second expiry sets status bit 1 but raises no reset request and leaves the boot flag clear.
- R8: Writing to address 3 clears each status bit whose written bit is 1 and leaves the others unchanged. If a set and a clear hit the same bit in the same cycle, the set wins.
- R9: Address 5 reads the live count in bits 9:0 and ignores writes. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| no_reboot_strap | input | 1 | Board strap that vetoes the reset request when 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| sys_reset_req | output | 1 | One-cycle system reset request |

## Verification
The properties assume that the register bus makes at most one write per cycle, so a period write and a reload never land on the same edge. They also assume that the strap is steady around an expiry, because the veto property compares a pulse with the previous cycle's veto state. The stimulus issues each write through a single task that strobes `reg_wr` for exactly one cycle, and it changes the strap only while the timer is halted. Expected pulse cycles are derived from the reload edge, the period and the prescale value, and they go into a queue that a monitor drains as the pulses appear.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  typedef enum logic [2:0] {
    REG_CTRL   = 3'd0,
    REG_KICK   = 3'd1,
    REG_PERIOD = 3'd2,
    REG_STATUS = 3'd3,
    REG_CFG    = 3'd4,
    REG_COUNT  = 3'd5
  } reg_addr_e;

  localparam int ST_TIMEOUT = 0;
  localparam int ST_SECOND  = 1;
  localparam int ST_BOOT    = 2;
  localparam int ST_W       = 3;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] ph_q, ph_d;
  logic          wrap;

  assign wrap = (ph_q == CW'(DIV - 1));
  assign tick = run && !clear && wrap;

  always_comb begin
    ph_d = ph_q;
    if (clear)    ph_d = '0;
    else if (run) ph_d = wrap ? '0 : ph_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_d;
  end
endmodule

// File: rtl/wdt2_counter.sv
module wdt2_counter #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic [PW-1:0] count,
  output logic          expire_first,
  output logic          expire_second
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          stage_q, stage_d;
  logic          expire;

  assign expire        = tick && !load && (cnt_q <= PW'(1));
  assign expire_first  = expire && !stage_q;
  assign expire_second = expire && stage_q;
  assign count         = cnt_q;

  always_comb begin
    cnt_d   = cnt_q;
    stage_d = stage_q;
    if (load) begin
      cnt_d   = period;
      stage_d = 1'b0;
    end else if (expire) begin
      cnt_d   = period;
      stage_d = !stage_q;
    end else if (tick) begin
      cnt_d   = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '1;
      stage_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      stage_q <= stage_d;
    end
  end
endmodule

// File: rtl/wdt2_regs.sv
module wdt2_regs
  import wdt2_pkg::*;
#(
  parameter int PW = 10,
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] count,
  input  logic          expire_first,
  input  logic          expire_second,
  input  logic          strap_nr,
  output logic          halt,
  output logic          kick,
  output logic [PW-1:0] period,
  output logic          cfg_nr,
  output logic [ST_W-1:0] status,
  output logic [DW-1:0] rdata,
  output logic          rst_req
);
  logic            halt_q, halt_d;
  logic [DW-1:0]   per_q, per_d;
  logic            nr_q, nr_d;
  logic [ST_W-1:0] sts_q, sts_d, sts_set, sts_clr;
  logic            req_d, req_q, veto;
  logic            wr_ctrl, wr_per, wr_sts, wr_cfg;

  assign wr_ctrl = wr_en && (addr == AW'(REG_CTRL));
  assign kick    = wr_en && (addr == AW'(REG_KICK));
  assign wr_per  = wr_en && (addr == AW'(REG_PERIOD));
  assign wr_sts  = wr_en && (addr == AW'(REG_STATUS));
  assign wr_cfg  = wr_en && (addr == AW'(REG_CFG));

  assign veto = strap_nr || nr_q;

  always_comb begin
    halt_d = wr_ctrl ? wdata[0] : halt_q;
    per_d  = wr_per  ? wdata    : per_q;
    nr_d   = wr_cfg  ? wdata[0] : nr_q;
    sts_clr = wr_sts ? wdata[ST_W-1:0] : '0;
    sts_set = '0;
    sts_set[ST_TIMEOUT] = expire_first;
    sts_set[ST_SECOND]  = expire_second;
    sts_set[ST_BOOT]    = expire_second && !veto;
    sts_d  = (sts_q & ~sts_clr) | sts_set;
    req_d  = expire_second && !veto;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      per_q  <= DW'((1 << PW) - 1);
      nr_q   <= 1'b0;
      sts_q  <= '0;
      req_q  <= 1'b0;
    end else begin
      halt_q <= halt_d;
      per_q  <= per_d;
      nr_q   <= nr_d;
      sts_q  <= sts_d;
      req_q  <= req_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      AW'(REG_CTRL):   rdata[0]        = halt_q;
      AW'(REG_PERIOD): rdata           = per_q;
      AW'(REG_STATUS): rdata[ST_W-1:0] = sts_q;
      AW'(REG_CFG):    rdata[0]        = nr_q;
      AW'(REG_COUNT):  rdata[PW-1:0]   = count;
      default:         rdata           = '0;
    endcase
  end

  assign halt    = halt_q;
  assign period  = per_q[PW-1:0];
  assign cfg_nr  = nr_q;
  assign status  = sts_q;
  assign rst_req = req_q;
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import wdt2_pkg::*;
#(
  parameter int PRESCALE = 8,
  parameter int PERIOD_W = 10,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              no_reboot_strap,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              sys_reset_req
);
  logic                rst_meta, rst_sync_n;
  logic                halt, kick, tick, cfg_nr;
  logic                exp_first, exp_second;
  logic [PERIOD_W-1:0] period_field, count;
  logic [ST_W-1:0]     status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  wdt2_prescaler #(.DIV(PRESCALE)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (!halt),
    .clear (kick),
    .tick  (tick)
  );

  wdt2_counter #(.PW(PERIOD_W)) u_cnt (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .load          (kick),
    .tick          (tick),
    .period        (period_field),
    .count         (count),
    .expire_first  (exp_first),
    .expire_second (exp_second)
  );

  wdt2_regs #(.PW(PERIOD_W), .DW(DATA_W), .AW(ADDR_W)) u_regs (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .wr_en         (reg_wr),
    .addr          (reg_addr),
    .wdata         (reg_wdata),
    .count         (count),
    .expire_first  (exp_first),
    .expire_second (exp_second),
    .strap_nr      (no_reboot_strap),
    .halt          (halt),
    .kick          (kick),
    .period        (period_field),
    .cfg_nr        (cfg_nr),
    .status        (status),
    .rdata         (reg_rdata),
    .rst_req       (sys_reset_req)
  );
endmodule

// File: rtl/twostage_wdt_chk.sv
module twostage_wdt_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          strap,
  input logic          cfg_nr,
  input logic [2:0]    status,
  input logic          halt,
  input logic          kick,
  input logic [PW-1:0] count,
  input logic [PW-1:0] period
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R6

  AST_PULSE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> (status[1] && status[2])); // R6

  AST_VETO_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> !$past(strap || cfg_nr)); // R7

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(halt) && !$past(kick)) |-> $stable(count)); // R2

  AST_KICK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(kick) |-> (count == $past(period))); // R3
endmodule

bind twostage_wdt twostage_wdt_chk #(.PW(PERIOD_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .rst_req (sys_reset_req),
  .strap   (no_reboot_strap),
  .cfg_nr  (cfg_nr),
  .status  (status),
  .halt    (halt),
  .kick    (kick),
  .count   (count),
  .period  (period_field)
);

// File: tb/twostage_wdt_test.sv
module twostage_wdt_test;
  localparam int DIV = 8;
  localparam int P   = 5;
  localparam int T   = P * DIV;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        strap;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        sys_reset_req;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int exp_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twostage_wdt #(.PRESCALE(DIV)) uut (
    .clk             (clk),
    .rst_n           (rst_n),
    .no_reboot_strap (strap),
    .reg_wr          (reg_wr),
    .reg_addr        (reg_addr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .sys_reset_req   (sys_reset_req)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, output int w);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    w = cyc;
  endtask

  task automatic peek(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Scoreboard driver side: expected reset pulse edge
  task automatic expect_pulse(input int edge_no);
    exp_q.push_back(edge_no);
  endtask

  // Monitor: every reset pulse must match the head of the queue (R6, R7)
  always @(negedge clk) begin
    if (rst_n && sys_reset_req) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 unexpected reset pulse actual=%0d expected=none", cyc);
      end else begin
        int e;
        e = exp_q.pop_front();
        checks++;
        if (e != cyc) begin
          fails++;
          $display("FAIL R6 reset pulse cycle actual=%0d expected=%0d", cyc, e);
        end
      end
    end
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int w, w2, h, hu;
    rst_n = 1'b0; strap = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    peek(3'd0, d); check("R1 halt", d, 16'h0001);
    peek(3'd2, d); check("R1 period", d, 16'h03FF);
    peek(3'd3, d); check("R1 status", d, 16'h0000);
    peek(3'd4, d); check("R1 veto", d, 16'h0000);
    peek(3'd5, d); check("R1 count", d, 16'h03FF);
    check("R1 reset_req", {15'd0, sys_reset_req}, 16'h0000);

    // R4 upper bits stored, period field used
    wr(3'd2, 16'hA800 | 16'(P), w);
    peek(3'd2, d); check("R4 period readback", d, 16'hA800 | 16'(P));
    peek(3'd6, d); check("R9 unused address", d, 16'h0000);

    // R3 reload while halted, R2 no counting while halted
    wr(3'd1, 16'h1234, w);
    peek(3'd5, d); check("R3 load while halted", d, 16'(P));
    wait_until(w + 60);
    peek(3'd5, d); check("R2 count frozen", d, 16'(P));
    peek(3'd3, d); check("R2 no expiry while halted", d, 16'h0000);
    wr(3'd5, 16'h0077, w);
    peek(3'd5, d); check("R9 count ignores writes", d, 16'(P));

    // R5 R6 two-stage expiry
    wr(3'd0, 16'h0000, w);
    wr(3'd1, 16'h0000, w);
    expect_pulse(w + 2 * T);
    expect_pulse(w + 4 * T);
    wait_until(w + T - 1);
    peek(3'd3, d); check("R5 no timeout yet", d, 16'h0000);
    peek(3'd5, d); check("R5 count one tick left", d, 16'h0001);
    wait_until(w + T);
    peek(3'd3, d); check("R5 timeout flag", d, 16'h0001);
    peek(3'd5, d); check("R6 count refilled", d, 16'(P));
    wait_until(w + 2 * T - 1);
    peek(3'd3, d); check("R6 before second", d, 16'h0001);
    wait_until(w + 2 * T);
    peek(3'd3, d); check("R6 second and boot flags", d, 16'h0007);

    // R8 write-one-to-clear
    wr(3'd3, 16'h0002, w2);
    peek(3'd3, d); check("R8 clear bit1", d, 16'h0005);
    wr(3'd3, 16'h0000, w2);
    peek(3'd3, d); check("R8 zero write", d, 16'h0005);
    wr(3'd3, 16'h0005, w2);
    peek(3'd3, d); check("R8 clear rest", d, 16'h0000);

    // R6 repeats every two periods
    wait_until(w + 3 * T);
    peek(3'd3, d); check("R6 re-armed first", d, 16'h0001);
    wait_until(w + 4 * T);
    peek(3'd3, d); check("R6 repeat second", d, 16'h0007);
    wr(3'd0, 16'h0001, w2);

    // R3 reload between expiries prevents second
    wr(3'd3, 16'h0007, w2);
    wr(3'd0, 16'h0000, w2);
    wr(3'd1, 16'h0000, w);
    wait_until(w + T + 10);
    peek(3'd3, d); check("R3 first expiry", d, 16'h0001);
    wr(3'd1, 16'h0000, w2);
    expect_pulse(w2 + 2 * T);
    wait_until(w2 + 2 * T - 1);
    peek(3'd3, d); check("R3 reload blocked second", d, 16'h0001);
    wait_until(w2 + 2 * T + 1);
    wr(3'd0, 16'h0001, w2);

    // R7 veto by config bit
    wr(3'd3, 16'h0007, w2);
    wr(3'd4, 16'h0001, w2);
    wr(3'd0, 16'h0000, w2);
    wr(3'd1, 16'h0000, w);
    wait_until(w + 2 * T + 2);
    peek(3'd3, d); check("R7 config veto flags", d, 16'h0003);
    wr(3'd0, 16'h0001, w2);

    // R7 veto by strap
    wr(3'd3, 16'h0007, w2);
    wr(3'd4, 16'h0000, w2);
    strap = 1'b1;
    wr(3'd0, 16'h0000, w2);
    wr(3'd1, 16'h0000, w);
    wait_until(w + 2 * T + 2);
    peek(3'd3, d); check("R7 strap veto flags", d, 16'h0003);
    wr(3'd0, 16'h0001, w2);
    strap = 1'b0;

    // R2 freeze mid-count and resume phase
    wr(3'd3, 16'h0007, w2);
    wr(3'd0, 16'h0000, w2);
    wr(3'd1, 16'h0000, w);
    wait_until(w + 19);
    wr(3'd0, 16'h0001, h);
    peek(3'd5, d); check("R2 count at halt", d, 16'(P - 2));
    wait_until(h + 60);
    peek(3'd5, d); check("R2 count held", d, 16'(P - 2));
    wr(3'd0, 16'h0000, hu);
    wait_until(hu + 2);
    peek(3'd5, d); check("R2 resume phase kept", d, 16'(P - 2));
    wait_until(hu + 3);
    peek(3'd5, d); check("R2 resume tick", d, 16'(P - 3));
    wr(3'd0, 16'h0001, w2);

    repeat (5) @(negedge clk);
    while (exp_q.size() != 0) begin
      int e;
      e = exp_q.pop_front();
      checks++; fails++;
      $display("FAIL R6 missing reset pulse actual=none expected=%0d", e);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule